// File: doc/BRIEF.md
# Universal Frequency and Period Counter

This block measures an external signal against the reference clock. Two signal pins feed it: a high-band pin and a low-band pin. In frequency mode it counts the rising edges of the selected pin during a gate window. In period mode it counts reference ticks from the first to the last rising edge of the low-band pin that fall inside that window. The gate window is a whole number of milliseconds. A prescaler builds each millisecond from `TICKS_PER_MS` reference cycles.

Three write strobes set the configuration: one for the measurement mode, one for the gate length and one for the pin-function select. A single-cycle `start` begins a measurement. When the window closes, `done` is raised and `count` holds the result. Either pin can instead serve as a plain input bit, read through `gp_bits`. While `clk_stop` is high, both pins are forced low before they reach any logic.

Top module: `unicnt_top`

## Requirements
- R1: After reset, `done`=0, `count`=0 and `gp_bits`=00. The mode is high-band frequency (code 00), so a measurement started after only a gate write counts the high-band pin.
- R2: Mode code 00 counts rising edges of `hb_in` that occur inside the gate window.
- R3: Mode code 01 counts rising edges of `lb_in` inside the gate window. Edges on `hb_in` are not counted.
- R4: Mode code 10 sets `count` to the number of reference cycles between the first and the last rising edge of `lb_in` inside the gate window.
- R5: Gate code 00, 01, 10 and 11 selects 1, 4, 8 and 16 ms, with one ms equal to `TICKS_PER_MS` cycles. `done` rises exactly G·TICKS_PER_MS cycles after the clock edge that accepts `start`.
- R6: `start` is ignored until a gate code has been written since reset.
- R7: An accepted `start` clears `done` and `count` at the accepting edge.
- R8: `done` stays high, and `count` stays unchanged, until the next accepted `start`. Pin activity while idle has no effect on either.
- R9: `count` saturates at 2^CNT_W−1 and does not wrap.
- R10: Select bit i set (bit 0 = `hb_in`, bit 1 = `lb_in`) makes that pin appear on `gp_bits[i]` after two synchronizing cycles, and removes the pin from the counter. With select bit i clear, `gp_bits[i]` reads 0.
- R11: While `clk_stop` is high, both pins read low: `gp_bits` becomes 00 and no edges are counted.
- R12: While a measurement runs, configuration writes and further `start` strobes are ignored. `start` with mode code 11 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_in | input | 1 | High-band signal pin (asynchronous) |
| lb_in | input | 1 | Low-band signal pin (asynchronous) |
| clk_stop | input | 1 | Forces both pins low |
| mode_we | input | 1 | Write strobe for the mode code |
| mode_wd | input | 2 | Mode code: 00 hb freq, 01 lb freq, 10 lb period, 11 reserved |
| gate_we | input | 1 | Write strobe for the gate code |
| gate_wd | input | 2 | Gate code: 1/4/8/16 ms |
| gpsel_we | input | 1 | Write strobe for the pin-function select |
| gpsel_wd | input | 2 | Per-pin general-purpose select |
| start | input | 1 | Single-cycle measurement start |
| done | output | 1 | Measurement complete flag |
| count | output | CNT_W | Measurement result |
| gp_bits | output | 2 | General-purpose input bits |

## Verification
The assertions assume that the pins change no faster than once per reference cycle. They also assume that `clk_stop` stays high for at least three cycles whenever the input-disable property is expected to apply. The stimulus drives every input on the falling clock edge and holds each pin level for at least one full cycle. Every pulse train is placed well inside the gate window, so the two-cycle synchronizer delay can never carry an edge across the window boundary. `clk_stop` is held for many cycles at a time.

// File: rtl/unicnt_pkg.sv
package unicnt_pkg;

  typedef enum logic [1:0] {
    MODE_FREQ_HB = 2'b00,
    MODE_FREQ_LB = 2'b01,
    MODE_PER_LB  = 2'b10,
    MODE_RSVD    = 2'b11
  } meas_mode_e;

  localparam int unsigned MAX_GATE_MS = 16;
  localparam int unsigned MS_W        = $clog2(MAX_GATE_MS) + 1;

  // gate code -> window length in milliseconds
  function automatic int unsigned gate_ms(input logic [1:0] code);
    case (code)
      2'b00:   gate_ms = 1;
      2'b01:   gate_ms = 4;
      2'b10:   gate_ms = 8;
      default: gate_ms = 16;
    endcase
  endfunction

endpackage

// File: rtl/unicnt_insync.sv
module unicnt_insync #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] rise_o
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~prev_q;
  end

endmodule

// File: rtl/unicnt_gate.sv
module unicnt_gate
  import unicnt_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [1:0] gate_code_i,
  output logic       last_o
);

  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [MS_W-1:0]  ms_q,  ms_n;
  logic             pre_wrap;
  logic [MS_W-1:0]  ms_last;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign ms_last  = MS_W'(gate_ms(gate_code_i) - 1);
  assign last_o   = run_i && pre_wrap && (ms_q == ms_last);

  always_comb begin
    pre_n = pre_q;
    ms_n  = ms_q;
    if (clr_i) begin
      pre_n = '0;
      ms_n  = '0;
    end else if (run_i) begin
      if (pre_wrap) begin
        pre_n = '0;
        ms_n  = ms_q + 1'b1;
      end else begin
        pre_n = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_n;
      ms_q  <= ms_n;
    end
  end

endmodule

// File: rtl/unicnt_accum.sv
module unicnt_accum #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             period_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q, count_n;
  logic [CNT_W-1:0] acc_q, acc_n;
  logic             arm_q, arm_n;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    sat_inc = (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_comb begin
    count_n = count_q;
    acc_n   = acc_q;
    arm_n   = arm_q;
    if (clr_i) begin
      count_n = '0;
      acc_n   = '0;
      arm_n   = 1'b0;
    end else if (en_i) begin
      if (period_i) begin
        if (arm_q) begin
          acc_n = sat_inc(acc_q);
          if (edge_i) count_n = acc_n;
        end else if (edge_i) begin
          arm_n = 1'b1;
          acc_n = '0;
        end
      end else if (edge_i) begin
        count_n = sat_inc(count_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      acc_q   <= '0;
      arm_q   <= 1'b0;
    end else begin
      count_q <= count_n;
      acc_q   <= acc_n;
      arm_q   <= arm_n;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/unicnt_top.sv
module unicnt_top
  import unicnt_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int CNT_W        = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hb_in,
  input  logic             lb_in,
  input  logic             clk_stop,
  input  logic             mode_we,
  input  logic [1:0]       mode_wd,
  input  logic             gate_we,
  input  logic [1:0]       gate_wd,
  input  logic             gpsel_we,
  input  logic [1:0]       gpsel_wd,
  input  logic             start,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       gp_bits
);

  localparam int NPIN = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  // configuration and control state
  meas_mode_e mode_q,  mode_n;
  logic [1:0] gate_q,  gate_n;
  logic       gate_ok_q, gate_ok_n;
  logic [1:0] gpsel_q, gpsel_n;
  logic       busy_q,  busy_n;
  logic       done_q,  done_n;

  logic            accept;
  logic            win_last;
  logic [NPIN-1:0] pin_m, pin_lvl, pin_rise;
  logic            sel_idx;
  logic            sel_rise;

  assign pin_m = {lb_in, hb_in} & {NPIN{~clk_stop}};

  unicnt_insync #(.NPIN(NPIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .pin_i  (pin_m),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise)
  );

  assign sel_idx  = (mode_q != MODE_FREQ_HB);
  assign sel_rise = pin_rise[sel_idx] & ~gpsel_q[sel_idx];
  assign accept   = start && !busy_q && gate_ok_q && (mode_q != MODE_RSVD);

  always_comb begin
    mode_n    = mode_q;
    gate_n    = gate_q;
    gate_ok_n = gate_ok_q;
    gpsel_n   = gpsel_q;
    busy_n    = busy_q;
    done_n    = done_q;
    if (!busy_q) begin
      if (mode_we)  mode_n  = meas_mode_e'(mode_wd);
      if (gpsel_we) gpsel_n = gpsel_wd;
      if (gate_we) begin
        gate_n    = gate_wd;
        gate_ok_n = 1'b1;
      end
    end
    if (accept) begin
      busy_n = 1'b1;
      done_n = 1'b0;
    end else if (win_last) begin
      busy_n = 1'b0;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q    <= MODE_FREQ_HB;
      gate_q    <= 2'b00;
      gate_ok_q <= 1'b0;
      gpsel_q   <= 2'b00;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      mode_q    <= mode_n;
      gate_q    <= gate_n;
      gate_ok_q <= gate_ok_n;
      gpsel_q   <= gpsel_n;
      busy_q    <= busy_n;
      done_q    <= done_n;
    end
  end

  unicnt_gate #(.TICKS_PER_MS(TICKS_PER_MS)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .clr_i       (accept),
    .run_i       (busy_q),
    .gate_code_i (gate_q),
    .last_o      (win_last)
  );

  unicnt_accum #(.CNT_W(CNT_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr_i    (accept),
    .en_i     (busy_q),
    .period_i (mode_q == MODE_PER_LB),
    .edge_i   (sel_rise),
    .count_o  (count)
  );

  assign done    = done_q;
  assign gp_bits = pin_lvl & gpsel_q;

endmodule

// File: rtl/unicnt_chk.sv
module unicnt_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_stop,
  input logic             start,
  input logic             done,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       gp_bits,
  input logic             busy,
  input logic             gate_ok,
  input logic [1:0]       mode
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R7: a new run begins with a cleared flag and count
  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!done && count == '0));

  // R8: the flag holds until something restarts the engine
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8: count frozen while idle
  p_count_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || $stable(count)));

  // R5: completion only ends a running window
  p_done_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R5: never done and running together
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: saturated count does not wrap except by a clear
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX) |=> (count == CNT_MAX || count == '0));

  // R6: no run without a chosen gate
  p_need_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_ok && !busy) |=> !busy);

  // R11: held input disable drives the general-purpose bits low
  p_stop_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && $past(clk_stop) && $past(clk_stop, 2)) |-> (gp_bits == 2'b00));

  // R12: configuration locked during a run
  p_cfg_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));

endmodule

bind unicnt_top unicnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_i),
  .clk_stop (clk_stop),
  .start    (start),
  .done     (done),
  .count    (count),
  .gp_bits  (gp_bits),
  .busy     (busy_q),
  .gate_ok  (gate_ok_q),
  .mode     (mode_q)
);

// File: tb/unicnt_top_tb_top.sv
module unicnt_top_tb_top;

  localparam int T     = 50;
  localparam int CW    = 8;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          hb_in, lb_in, clk_stop;
  logic          mode_we, gate_we, gpsel_we;
  logic [1:0]    mode_wd, gate_wd, gpsel_wd;
  logic          start;
  logic          done;
  logic [CW-1:0] count;
  logic [1:0]    gp_bits;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_cnt = 0;

  typedef struct {
    int    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  unicnt_top #(.TICKS_PER_MS(T), .CNT_W(CW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hb_in    (hb_in),
    .lb_in    (lb_in),
    .clk_stop (clk_stop),
    .mode_we  (mode_we),
    .mode_wd  (mode_wd),
    .gate_we  (gate_we),
    .gate_wd  (gate_wd),
    .gpsel_we (gpsel_we),
    .gpsel_wd (gpsel_wd),
    .start    (start),
    .done     (done),
    .count    (count),
    .gp_bits  (gp_bits)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: compare each completed measurement against the scoreboard
  always begin
    @(posedge done);
    @(negedge clk);
    if (sb_q.size() == 0) begin
      chk(1'b0, "R8 unexpected completion", 1, 0);
    end else begin
      item_t it;
      it = sb_q.pop_front();
      chk(int'(count) == it.exp, it.tag, int'(count), it.exp);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  task automatic wr_mode(input logic [1:0] v);
    mode_we = 1'b1; mode_wd = v; @(negedge clk); mode_we = 1'b0;
  endtask
  task automatic wr_gate(input logic [1:0] v);
    gate_we = 1'b1; gate_wd = v; @(negedge clk); gate_we = 1'b0;
  endtask
  task automatic wr_gpsel(input logic [1:0] v);
    gpsel_we = 1'b1; gpsel_wd = v; @(negedge clk); gpsel_we = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_pin(input int pin, input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      if (pin == 0) hb_in = 1'b1; else lb_in = 1'b1;
      repeat (hi) @(negedge clk);
      if (pin == 0) hb_in = 1'b0; else lb_in = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  // driver: queue expectation, start, stimulate, wait for completion
  task automatic measure(input int exp, input string tag, input int pin,
                         input int offs, input int n, input int hi, input int lo);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    do_start();
    repeat (offs) @(negedge clk);
    pulse_pin(pin, n, hi, lo);
    wait_done();
  endtask

  initial begin
    int t0;
    item_t it;
    rst_n = 1'b0; hb_in = 1'b0; lb_in = 1'b0; clk_stop = 1'b0;
    mode_we = 1'b0; gate_we = 1'b0; gpsel_we = 1'b0;
    mode_wd = 2'b00; gate_wd = 2'b00; gpsel_wd = 2'b00; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(count == '0, "R1 count after reset", int'(count), 0);
    chk(gp_bits == 2'b00, "R1 gp_bits after reset", int'(gp_bits), 0);

    // R6: start before any gate write is ignored
    do_start();
    repeat (80) @(negedge clk);
    chk(done == 1'b0, "R6 start without gate", int'(done), 0);

    // R1: default mode counts the high-band pin
    wr_gate(2'b00);
    measure(6, "R1 default high-band frequency", 0, 5, 6, 2, 2);

    // R2: high-band frequency, 4 ms gate
    wr_mode(2'b00);
    wr_gate(2'b01);
    measure(30, "R2 high-band frequency", 0, 10, 30, 2, 2);

    // R3: low-band frequency, high-band activity ignored
    wr_mode(2'b01);
    it.exp = 5; it.tag = "R3 low-band frequency";
    sb_q.push_back(it);
    do_start();
    repeat (5) @(negedge clk);
    pulse_pin(0, 9, 2, 2);
    pulse_pin(1, 5, 2, 2);
    wait_done();

    // R4: low-band period, 5 edges spaced 30 cycles
    wr_mode(2'b10);
    measure(120, "R4 low-band period", 1, 10, 5, 15, 15);

    // R5: window lengths
    wr_mode(2'b00);
    wr_gate(2'b10);
    it.exp = 0; it.tag = "R5 empty 8 ms window";
    sb_q.push_back(it);
    do_start();
    t0 = cyc_cnt;
    while (!done && cyc_cnt - t0 < 3000) @(negedge clk);
    chk(cyc_cnt - t0 == 8 * T, "R5 8 ms window length", cyc_cnt - t0, 8 * T);
    @(negedge clk); @(negedge clk);
    wr_gate(2'b11);
    it.exp = 0; it.tag = "R5 empty 16 ms window";
    sb_q.push_back(it);
    do_start();
    t0 = cyc_cnt;
    while (!done && cyc_cnt - t0 < 3000) @(negedge clk);
    chk(cyc_cnt - t0 == 16 * T, "R5 16 ms window length", cyc_cnt - t0, 16 * T);
    @(negedge clk); @(negedge clk);

    // R7: start clears flag and count
    wr_gate(2'b00);
    it.exp = 3; it.tag = "R7 count after restart";
    sb_q.push_back(it);
    do_start();
    chk(done == 1'b0 && count == '0, "R7 cleared at start", int'(done) + int'(count), 0);
    repeat (5) @(negedge clk);
    pulse_pin(0, 3, 2, 2);
    wait_done();

    // R8: idle pin activity changes nothing
    repeat (20) @(negedge clk);
    pulse_pin(0, 4, 2, 2);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R8 done held", int'(done), 1);
    chk(int'(count) == 3, "R8 count held", int'(count), 3);

    // R9: saturation
    wr_gate(2'b11);
    measure(CMAX, "R9 saturated frequency", 0, 10, 300, 1, 1);

    // R12: reserved mode does not start
    wr_mode(2'b11);
    do_start();
    repeat (60) @(negedge clk);
    chk(done == 1'b1 && int'(count) == CMAX, "R12 reserved mode start", int'(count), CMAX);

    // R12: writes and starts during a run are ignored
    wr_mode(2'b00);
    wr_gate(2'b01);
    it.exp = 4; it.tag = "R12 run unaffected by writes";
    sb_q.push_back(it);
    do_start();
    t0 = cyc_cnt;
    repeat (5) @(negedge clk);
    wr_mode(2'b01);
    do_start();
    pulse_pin(0, 4, 2, 2);
    while (!done && cyc_cnt - t0 < 3000) @(negedge clk);
    chk(cyc_cnt - t0 == 4 * T, "R12 window not restarted", cyc_cnt - t0, 4 * T);
    @(negedge clk); @(negedge clk);
    measure(2, "R12 mode write was dropped", 0, 5, 2, 2, 2);

    // R10: general-purpose routing
    wr_gpsel(2'b01);
    hb_in = 1'b1; lb_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(gp_bits == 2'b01, "R10 hb as input bit", int'(gp_bits), 1);
    hb_in = 1'b0; lb_in = 1'b0;
    wr_gate(2'b00);
    repeat (3) @(negedge clk);
    measure(0, "R10 input-bit pin not counted", 0, 5, 6, 2, 2);
    wr_gpsel(2'b11);
    lb_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(gp_bits == 2'b10, "R10 lb as input bit", int'(gp_bits), 2);

    // R11: input disable
    hb_in = 1'b1;
    clk_stop = 1'b1;
    repeat (4) @(negedge clk);
    chk(gp_bits == 2'b00, "R11 pins read low", int'(gp_bits), 0);
    hb_in = 1'b0; lb_in = 1'b0;
    wr_gpsel(2'b00);
    wr_mode(2'b01);
    measure(0, "R11 no edges counted", 1, 5, 6, 2, 2);
    clk_stop = 1'b0;
    repeat (4) @(negedge clk);

    chk(sb_q.size() == 0, "R8 all completions seen", sb_q.size(), 0);
    finish_run();
  end

endmodule